// File: doc/BRIEF.md
# Two-to-one half-band IIR decimator with polyphase allpass branches

This block halves the sample rate of one real, signed 16-bit stream. Its low-pass filter is a fifth-order elliptic half-band IIR, written as the sum of two allpass paths that work on alternate input samples. Each path is a single first-order section in z², with one coefficient. Because each path runs at the output rate, the whole filter needs only two multipliers. The delay storage is also half of what a full-rate filter would need.

Input samples arrive with a single-cycle strobe and there is no backpressure. The first accepted sample after reset is treated as even. Even samples go to the path that uses coefficient C0. Odd samples go to the path that uses coefficient C1, after one low-rate delay. When the odd sample of a pair is accepted, both sections advance once. Their outputs are averaged and then rounded and saturated to 16 bits. The result appears on a one-cycle output strobe.

Top module: `hb_decim2`

## Requirements
- R1: A synchronous active-low reset clears every section register, both sample holding registers, the output and the pair phase. While reset is held, `out_valid` is 0. The first sample accepted after reset is the even sample of a pair.
- R2: In a cycle where `in_valid` is 0, `in_data` is ignored and no state changes. A stall of any length between two strobes leaves the results unchanged.
- R3: `out_valid` pulses for exactly one cycle per pair of accepted samples. The pulse appears in the cycle after the edge that accepted the odd sample. No pulse follows the acceptance of an even sample.
- R4: Each 16-bit input is widened to 24 bits before filtering. The widened word is the sign bit (guard), then the 16 data bits, then 7 zero fractional bits. In other words, the input value is multiplied by 128.
- R5: Every section computes y = xprev + round(c·(x − yprev)) once per pair. Here xprev and yprev are the values from the previous pair. The coefficient c is a signed 18-bit value with 17 fractional bits, and the product is rounded half-up back to the 24-bit format.
- R6: The path with C0 (default 18088, about 0.1380) is fed the even sample of the current pair. The path with C1 (default 76637, about 0.5847) is fed the odd sample of the previous pair. As a result, an odd sample first affects the output of the following pair. Before the first odd sample, that path is fed zero.
- R7: The output is (y0 + y1) arithmetically shifted right by one. That value is rounded half-up at its 7 fractional bits and saturated to the range −32768..32767.
- R8: Any section result that does not fit in 24 signed bits is saturated to −2^23 or 2^23−1 before it is stored and used.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output strobe, one per input pair |
| out_data | output | 16 | Signed decimated output sample |

## Verification
Two events can fall in the same cycle: the output strobe of one pair and the acceptance of the next pair's even sample. Streaming samples back-to-back makes them coincide every other cycle. The bench checks that the emitted value matches its own arithmetic model, and that the next result reflects the newly captured even sample. A second coincidence is checked in the same way. On each odd acceptance, both sections update while the odd-delay register is overwritten. Patterns with distinct odd values show whether the C1 path used the old odd sample or the new one.

// File: rtl/hb_pkg.sv
// Package: shared widths and default coefficients of the half-band decimator.
// Assumes a 16-bit input with 7 fractional bits and 1 guard bit in a 24-bit datapath.
package hb_pkg;
    localparam int HB_DATA_W   = 16;
    localparam int HB_FRAC_IN  = 7;
    localparam int HB_ACC_W    = HB_DATA_W + HB_FRAC_IN + 1;
    localparam int HB_COEF_W   = 18;
    localparam int HB_COEF_FR  = 17;
    localparam int HB_C0_DEF   = 18088;
    localparam int HB_C1_DEF   = 76637;
endpackage

// File: rtl/hb_ap_section.sv
// Module: one allpass section in z^2, running at the low rate.
// Computes y = xprev + round(c*(x - yprev)) each cycle that 'step' is high.
// Saturates y to ACC_W bits. Assumes the coefficient is a signed Q1.(COEF_FR) value.
module hb_ap_section #(
    parameter int ACC_W   = 24,
    parameter int COEF_W  = 18,
    parameter int COEF_FR = 17,
    parameter int COEF    = 18088
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic signed [ACC_W-1:0] x_in,
    output logic signed [ACC_W-1:0] y_out
);
    localparam int DW = ACC_W + 1;
    localparam int PW = DW + COEF_W;
    localparam logic signed [COEF_W-1:0] CF = COEF_W'(COEF);
    localparam logic signed [PW-1:0] RND_HALF = PW'(64'sd1 <<< (COEF_FR - 1));
    localparam logic signed [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W-1:0] xp, yp;
    logic signed [DW-1:0]    diff;
    logic signed [PW-1:0]    prod, rnd, ext;

    // Pre-adder, multiplier, rounding and post-adder with 24-bit saturation.
    always_comb begin
        diff = {x_in[ACC_W-1], x_in} - {yp[ACC_W-1], yp};
        prod = PW'(diff) * PW'(CF);
        rnd  = (prod + RND_HALF) >>> COEF_FR;
        ext  = PW'(xp) + rnd;
        if (ext[PW-1:ACC_W-1] == '0 || ext[PW-1:ACC_W-1] == '1)
            y_out = ext[ACC_W-1:0];
        else
            y_out = ext[PW-1] ? NEG_LIM : POS_LIM;
    end

    // Input-side and output-side delay registers, one low-rate sample each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xp <= '0;
            yp <= '0;
        end else if (step) begin
            xp <= x_in;
            yp <= y_out;
        end
    end

    // R2: the section state holds while the section is not stepped.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(xp) && $stable(yp)));
    // R5: the input-side delay captures the stepped input.
    assert_xdelay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (xp == $past(x_in)));
endmodule

// File: rtl/hb_combiner.sv
// Module: averages the two branch outputs and rounds/saturates them to the output width.
// Assumes the input words carry FRAC_IN fractional bits.
module hb_combiner #(
    parameter int DATA_W  = 16,
    parameter int FRAC_IN = 7,
    parameter int ACC_W   = DATA_W + FRAC_IN + 1
) (
    input  logic signed [ACC_W-1:0]  y0,
    input  logic signed [ACC_W-1:0]  y1,
    output logic signed [DATA_W-1:0] q
);
    localparam logic signed [ACC_W:0] RND_HALF = (ACC_W+1)'(64'sd1 <<< (FRAC_IN - 1));
    localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W:0]   sum, hx, sh;
    logic signed [ACC_W-1:0] half;

    // Sum, halve, round half-up at the fractional boundary, saturate.
    always_comb begin
        sum  = {y0[ACC_W-1], y0} + {y1[ACC_W-1], y1};
        half = sum[ACC_W:1];
        hx   = {half[ACC_W-1], half} + RND_HALF;
        sh   = hx >>> FRAC_IN;
        if (sh[ACC_W:DATA_W-1] == '0 || sh[ACC_W:DATA_W-1] == '1)
            q = sh[DATA_W-1:0];
        else
            q = sh[ACC_W] ? NEG_LIM : POS_LIM;
    end
endmodule

// File: rtl/hb_decim2.sv
// Module: top of the by-two half-band IIR decimator.
// Steers even samples to the C0 path and odd samples, through a one-pair delay, to the C1 path.
// Steps both sections on every odd sample and registers the combined result.
// Assumes at most one input strobe per cycle and no backpressure.
module hb_decim2 #(
    parameter int DATA_W  = hb_pkg::HB_DATA_W,
    parameter int FRAC_IN = hb_pkg::HB_FRAC_IN,
    parameter int COEF_W  = hb_pkg::HB_COEF_W,
    parameter int COEF_FR = hb_pkg::HB_COEF_FR,
    parameter int C0      = hb_pkg::HB_C0_DEF,
    parameter int C1      = hb_pkg::HB_C1_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int ACC_W = DATA_W + FRAC_IN + 1;

    logic                     phase;
    logic signed [ACC_W-1:0]  in_wide, even_hold, odd_dly;
    logic signed [ACC_W-1:0]  y0, y1;
    logic signed [DATA_W-1:0] q;
    logic                     step;

    // Place the input under one guard bit with FRAC_IN zero fractional bits.
    always_comb begin
        in_wide = {in_data[DATA_W-1], in_data, {FRAC_IN{1'b0}}};
        step    = in_valid && phase;
    end

    // Commutator: track the pair phase and hold the even and delayed odd samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= 1'b0;
            even_hold <= '0;
            odd_dly   <= '0;
        end else if (in_valid) begin
            phase <= ~phase;
            if (!phase) even_hold <= in_wide;
            else        odd_dly   <= in_wide;
        end
    end

    hb_ap_section #(.ACC_W(ACC_W), .COEF_W(COEF_W), .COEF_FR(COEF_FR), .COEF(C0)) u_sec0 (
        .clk(clk), .rst_n(rst_n), .step(step), .x_in(even_hold), .y_out(y0));

    hb_ap_section #(.ACC_W(ACC_W), .COEF_W(COEF_W), .COEF_FR(COEF_FR), .COEF(C1)) u_sec1 (
        .clk(clk), .rst_n(rst_n), .step(step), .x_in(odd_dly), .y_out(y1));

    hb_combiner #(.DATA_W(DATA_W), .FRAC_IN(FRAC_IN), .ACC_W(ACC_W)) u_comb (
        .y0(y0), .y1(y1), .q(q));

    // Output register: one strobe and one value per completed pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= step;
            if (step) out_data <= q;
        end
    end

    // R1: reset leaves the output idle and the phase at even.
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !phase));
    // R3: the output strobe never lasts two cycles.
    assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R3: every strobe follows the acceptance of an odd sample.
    assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && phase));
    // R2: an idle cycle keeps the phase and yields no strobe.
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(phase) && !out_valid));
endmodule

// File: tb/tb_hb_decim2.sv
`timescale 1ns/1ps
module tb_hb_decim2;
    localparam longint K0 = 18088;
    localparam longint K1 = 76637;
    localparam int NV = 16;
    localparam logic signed [15:0] VEC [NV] = '{
        16'sd1000, -16'sd2000, 16'sd3000, 16'sd500, -16'sd7000, 16'sd12000, 16'sd0, 16'sd42,
        16'sd20000, -16'sd20000, 16'sd1, -16'sd1, 16'sd32767, -16'sd32768, 16'sd123, 16'sd9999};

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic out_valid;
    logic [15:0] out_data;

    int n_run = 0, n_fail = 0;
    longint m_xp0, m_yp0, m_xp1, m_yp1, m_even, m_odd, m_exp;
    bit m_phase;

    hb_decim2 dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
                   .out_valid(out_valid), .out_data(out_data));

    always #4 clk = ~clk;

    function automatic longint clamp(longint v, int w);
        longint hi = (64'sd1 <<< (w - 1)) - 1;
        longint lo = -(64'sd1 <<< (w - 1));
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_xp0 = 0; m_yp0 = 0; m_xp1 = 0; m_yp1 = 0;
        m_even = 0; m_odd = 0; m_phase = 0; m_exp = 0;
    endtask

    // Reference arithmetic taken from R4..R8.
    task automatic model_feed(longint s);
        longint xw, d, r, y0, y1, h;
        xw = s * 128;
        if (!m_phase) begin
            m_even = xw;
            m_phase = 1;
        end else begin
            d = m_even - m_yp0; r = (d * K0 + 65536) >>> 17;
            y0 = clamp(m_xp0 + r, 24); m_xp0 = m_even; m_yp0 = y0;
            d = m_odd - m_yp1; r = (d * K1 + 65536) >>> 17;
            y1 = clamp(m_xp1 + r, 24); m_xp1 = m_odd; m_yp1 = y1;
            m_odd = xw;
            h = (y0 + y1) >>> 1;
            m_exp = clamp((h + 64) >>> 7, 16);
            m_phase = 0;
        end
    endtask

    // Drive one strobe at a falling edge and check the result at the next falling edge.
    task automatic feed(longint s, string req);
        bit odd;
        odd = m_phase;
        in_valid = 1'b1;
        in_data = 16'(s);
        model_feed(s);
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 16'hDEAD;
        check({req, " R3 strobe"}, longint'(out_valid), odd ? 1 : 0);
        if (odd) check({req, " R7 value"}, longint'($signed(out_data)), m_exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        // R1: idle output after reset.
        check("R1 reset strobe", longint'(out_valid), 0);
        check("R1 reset data", longint'(out_data), 0);

        // Table walk: back-to-back strobes, R5 and R6 arithmetic.
        for (int i = 0; i < NV; i++) feed(VEC[i], "R5 R6 table");

        // R2: stalls with garbage data must not disturb anything.
        feed(700, "R2 pre-stall");
        for (int i = 0; i < 5; i++) begin
            in_data = 16'(i * 4099);
            @(negedge clk);
            check("R2 idle strobe", longint'(out_valid), 0);
        end
        feed(-300, "R2 post-stall");

        // R1: reset in the middle of a pair restarts at the even phase.
        feed(5000, "R1 half pair");
        do_reset();
        feed(64, "R1 restart even");
        feed(-64, "R1 restart odd");
        feed(0, "R1 restart even2");
        feed(0, "R1 restart odd2");

        // R4: unit impulse, small values show the input placement.
        do_reset();
        feed(1, "R4 impulse");
        for (int i = 0; i < 7; i++) feed(0, "R4 tail");

        // R6: an odd-only impulse reaches the output one pair late.
        do_reset();
        feed(0, "R6 even");
        feed(8000, "R6 odd");
        check("R6 odd delayed", longint'($signed(out_data)), 0);
        for (int i = 0; i < 4; i++) feed(0, "R6 tail");

        // R7 and R8: full-scale steps and Nyquist patterns exercise saturation.
        do_reset();
        for (int i = 0; i < 24; i++) feed(32767, "R7 full scale");
        for (int i = 0; i < 24; i++) feed(-32768, "R7 neg full scale");
        for (int i = 0; i < 40; i++) feed((i % 4 < 2) ? 32767 : -32768, "R8 extreme");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule